// File: doc/BRIEF.md
# Multi-Cycle Sixteen-Bit Register Processor

This block is a small 16-bit processor: a controller state machine that drives a datapath. The datapath holds a program counter, an instruction register, sixteen 16-bit general registers, and one adder/subtractor with a zero output. Instructions and data share a single 16-bit memory port. The memory sits outside the block and answers a read one clock after the request.

Every instruction first spends one cycle reading the word at the program counter. It then spends one cycle latching and decoding that word. After that come one execute cycle, or two for a memory load, and control returns to fetch. The block understands seven operations. Any other opcode parks the processor in a halted state until reset. The intended use is a small sequencing engine whose program and data sit in an attached memory.

Top module: `fsmd_cpu`

## Requirements
- R1: Reset clears the program counter and all sixteen registers to zero. While reset is held, the block requests a read of address 0, does not write, and keeps halt_o low.
- R2: Each instruction begins with a fetch cycle that requests a read at the program counter and adds one to it. Then comes a decode cycle with neither read nor write. Then come the execute cycles, after which the next fetch follows.
- R3: Opcode 0000 (bits 15:12) loads register rn (bits 11:8) from memory. In the first execute cycle the block requests a read at the zero-extended bits 7:0. In the second it writes the returned word into rn.
- R4: Opcode 0001 uses one execute cycle. In it the block writes register rn to memory at the zero-extended bits 7:0.
- R5: Opcode 0010 uses one execute cycle. In it the block writes register rm (bits 7:4) to memory at the address held in register rn.
- R6: Opcode 0011 writes bits 7:0 into rn, zero-extended to 16 bits.
- R7: Opcode 0100 sets rn to rn + rm, modulo 2^16.
- R8: Opcode 0101 sets rn to rn - rm, modulo 2^16.
- R9: Opcode 0110 loads the program counter with the zero-extended bits 7:0 when register rn is zero. Otherwise the program counter keeps the already-incremented value.
- R10: An opcode of 0111 or above raises halt_o from the cycle after decode. From then on the block makes no memory access, and halt_o stays high until reset.
- R11: Read and write requests are never raised together. A write request appears only in the execute cycle of a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_re_o | output | 1 | Read request; data is due on mem_rdata_i after the next edge |
| mem_we_o | output | 1 | Write request, taken at the next edge |
| mem_rdata_i | input | 16 | Read data, registered by the memory |
| halt_o | output | 1 | High while halted on an unknown opcode |

## Verification
The bus is fully determined by the instruction stream, so the bench computes it cycle by cycle:
- A fetch request shows on the bus in the first cycle after reset and in the first cycle after each instruction completes.
- The decode cycle that follows is idle.
- A store's write appears in the third cycle of its instruction, and a load's read also appears in that third cycle.
- A register written by a load, immediate or arithmetic instruction becomes visible only through a later store.
- halt_o rises in the third cycle of an unknown opcode.

A behavioural instruction-level model expands each instruction into that exact cycle list. Every cycle, half a period after the edge, the bench compares the request, address, write data and halt output against the next entry. The final memory words written by each program are then checked against hand-computed values.

// File: rtl/fsmd_pkg.sv
package fsmd_pkg;
  localparam int DW   = 16;
  localparam int AW   = 16;
  localparam int NREG = 16;
  localparam int RAW  = $clog2(NREG);
  localparam int OPW  = 4;
  localparam int FW   = 8;  // direct / immediate / target field

  localparam logic [OPW-1:0] OP_LD  = 4'h0;
  localparam logic [OPW-1:0] OP_ST  = 4'h1;
  localparam logic [OPW-1:0] OP_STI = 4'h2;
  localparam logic [OPW-1:0] OP_LI  = 4'h3;
  localparam logic [OPW-1:0] OP_ADD = 4'h4;
  localparam logic [OPW-1:0] OP_SUB = 4'h5;
  localparam logic [OPW-1:0] OP_JZ  = 4'h6;

  typedef enum logic [1:0] {WS_ALU = 2'b00, WS_MEM = 2'b01, WS_IMM = 2'b10} wsel_e;
  typedef enum logic [1:0] {AS_PC = 2'b00, AS_DIR = 2'b01, AS_REG = 2'b10} asel_e;
  typedef enum logic [1:0] {ALU_ADD = 2'b00, ALU_SUB = 2'b01} alu_e;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_LD, S_LDW, S_ST, S_STI,
    S_LI, S_ADD, S_SUB, S_JZ, S_HALT
  } state_e;

  typedef struct packed {
    logic           ir_ld;
    logic           pc_inc;
    logic           jz;
    logic           rf_we;
    logic [RAW-1:0] rf_wa;
    wsel_e          rf_wsel;
    logic [RAW-1:0] r1_a;
    logic           r1_e;
    logic [RAW-1:0] r2_a;
    logic           r2_e;
    alu_e           alu_op;
    asel_e          addr_sel;
    logic           mem_re;
    logic           mem_we;
  } ctrl_t;
endpackage

// File: rtl/fsmd_alu.sv
module fsmd_alu
  import fsmd_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_e          op_i,
  output logic [DW-1:0] y_o,
  output logic          zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      default: y_o = a_i + b_i;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/fsmd_regfile.sv
module fsmd_regfile
  import fsmd_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [RAW-1:0] wa_i,
  input  logic [DW-1:0]  wd_i,
  input  logic [RAW-1:0] r1_a_i,
  input  logic           r1_e_i,
  output logic [DW-1:0]  r1_o,
  input  logic [RAW-1:0] r2_a_i,
  input  logic           r2_e_i,
  output logic [DW-1:0]  r2_o
);
  logic [DW-1:0] rd_arr [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         q <= '0;
      else if (we_i && wa_i == RAW'(g))    q <= wd_i;
    end
    assign rd_arr[g] = q;
  end

  // disabled read port returns zero
  assign r1_o = r1_e_i ? rd_arr[r1_a_i] : '0;
  assign r2_o = r2_e_i ? rd_arr[r2_a_i] : '0;
endmodule

// File: rtl/fsmd_ctrl.sv
module fsmd_ctrl
  import fsmd_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [OPW-1:0] dec_op_i,
  input  logic [DW-1:0]  ir_i,
  output ctrl_t          ctrl_o,
  output logic           halt_o
);
  state_e state_q, state_d;
  logic [RAW-1:0] rn, rm;

  assign rn = ir_i[8 +: RAW];
  assign rm = ir_i[4 +: RAW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_FETCH;
    else         state_q <= state_d;
  end

  always_comb begin
    ctrl_o  = '0;
    state_d = S_FETCH;
    halt_o  = 1'b0;
    unique case (state_q)
      S_FETCH: begin
        ctrl_o.addr_sel = AS_PC;
        ctrl_o.mem_re   = 1'b1;
        ctrl_o.pc_inc   = 1'b1;
        state_d         = S_DECODE;
      end
      S_DECODE: begin
        ctrl_o.ir_ld = 1'b1;
        unique case (dec_op_i)
          OP_LD:   state_d = S_LD;
          OP_ST:   state_d = S_ST;
          OP_STI:  state_d = S_STI;
          OP_LI:   state_d = S_LI;
          OP_ADD:  state_d = S_ADD;
          OP_SUB:  state_d = S_SUB;
          OP_JZ:   state_d = S_JZ;
          default: state_d = S_HALT;
        endcase
      end
      S_LD: begin
        ctrl_o.addr_sel = AS_DIR;
        ctrl_o.mem_re   = 1'b1;
        state_d         = S_LDW;
      end
      S_LDW: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.rf_wa   = rn;
        ctrl_o.rf_wsel = WS_MEM;
      end
      S_ST: begin
        ctrl_o.addr_sel = AS_DIR;
        ctrl_o.r2_a     = rn;
        ctrl_o.r2_e     = 1'b1;
        ctrl_o.mem_we   = 1'b1;
      end
      S_STI: begin
        ctrl_o.addr_sel = AS_REG;
        ctrl_o.r1_a     = rn;
        ctrl_o.r1_e     = 1'b1;
        ctrl_o.r2_a     = rm;
        ctrl_o.r2_e     = 1'b1;
        ctrl_o.mem_we   = 1'b1;
      end
      S_LI: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.rf_wa   = rn;
        ctrl_o.rf_wsel = WS_IMM;
      end
      S_ADD, S_SUB: begin
        ctrl_o.r1_a    = rn;
        ctrl_o.r1_e    = 1'b1;
        ctrl_o.r2_a    = rm;
        ctrl_o.r2_e    = 1'b1;
        ctrl_o.alu_op  = (state_q == S_SUB) ? ALU_SUB : ALU_ADD;
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.rf_wa   = rn;
        ctrl_o.rf_wsel = WS_ALU;
      end
      S_JZ: begin
        // rn + 0 through the ALU, zero flag picks the branch
        ctrl_o.r1_a   = rn;
        ctrl_o.r1_e   = 1'b1;
        ctrl_o.alu_op = ALU_ADD;
        ctrl_o.jz     = 1'b1;
      end
      S_HALT: begin
        halt_o  = 1'b1;
        state_d = S_HALT;
      end
      default: state_d = S_HALT;
    endcase
  end

  a_r2_fetch_then_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FETCH) |=> (state_q == S_DECODE));
  a_r11_no_rw_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_o.mem_re && ctrl_o.mem_we));
  a_r10_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (halt_o && !ctrl_o.mem_re && !ctrl_o.mem_we));
  a_r3_load_writeback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LD) |=> (ctrl_o.rf_we && ctrl_o.rf_wsel == WS_MEM));
endmodule

// File: rtl/fsmd_datapath.sv
module fsmd_datapath
  import fsmd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ctrl_t         ctrl_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [DW-1:0] ir_o
);
  logic [AW-1:0] pc_q;
  logic [DW-1:0] ir_q;
  logic [DW-1:0] r1, r2, alu_y, rf_wd;
  logic          alu_zero, pc_ld;
  logic [DW-1:0] field_ext;

  assign field_ext = {{(DW-FW){1'b0}}, ir_q[FW-1:0]};
  assign pc_ld     = ctrl_i.jz & alu_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pc_q <= '0;
    else if (pc_ld)         pc_q <= AW'(field_ext);
    else if (ctrl_i.pc_inc) pc_q <= pc_q + AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ir_q <= '0;
    else if (ctrl_i.ir_ld) ir_q <= mem_rdata_i;
  end

  always_comb begin
    unique case (ctrl_i.rf_wsel)
      WS_MEM:  rf_wd = mem_rdata_i;
      WS_IMM:  rf_wd = field_ext;
      default: rf_wd = alu_y;
    endcase
  end

  always_comb begin
    unique case (ctrl_i.addr_sel)
      AS_DIR:  mem_addr_o = AW'(field_ext);
      AS_REG:  mem_addr_o = AW'(r1);
      default: mem_addr_o = pc_q;
    endcase
  end

  assign mem_wdata_o = r2;
  assign ir_o        = ir_q;

  fsmd_regfile u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctrl_i.rf_we),
    .wa_i   (ctrl_i.rf_wa),
    .wd_i   (rf_wd),
    .r1_a_i (ctrl_i.r1_a),
    .r1_e_i (ctrl_i.r1_e),
    .r1_o   (r1),
    .r2_a_i (ctrl_i.r2_a),
    .r2_e_i (ctrl_i.r2_e),
    .r2_o   (r2)
  );

  fsmd_alu u_alu (
    .a_i    (r1),
    .b_i    (r2),
    .op_i   (ctrl_i.alu_op),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.pc_inc && !ctrl_i.jz) |=> (pc_q == $past(pc_q) + AW'(1)));
  a_r9_jz_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.jz && r1 == '0) |=> (pc_q == AW'({{(DW-FW){1'b0}}, $past(ir_q[FW-1:0])})));
  a_r9_jz_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.jz && r1 != '0) |=> $stable(pc_q));
endmodule

// File: rtl/fsmd_cpu.sv
module fsmd_cpu
  import fsmd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [15:0]   mem_addr_o,
  output logic [15:0]   mem_wdata_o,
  output logic          mem_re_o,
  output logic          mem_we_o,
  input  logic [15:0]   mem_rdata_i,
  output logic          halt_o
);
  ctrl_t         ctrl;
  logic [DW-1:0] ir;

  fsmd_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dec_op_i (mem_rdata_i[DW-1 -: OPW]),
    .ir_i     (ir),
    .ctrl_o   (ctrl),
    .halt_o   (halt_o)
  );

  fsmd_datapath u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctrl),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .ir_o        (ir)
  );

  assign mem_re_o = ctrl.mem_re;
  assign mem_we_o = ctrl.mem_we;

  a_r11_write_after_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
endmodule

// File: tb/fsmd_cpu_tb.sv
module fsmd_cpu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        mem_re, mem_we, halt;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsmd_cpu dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_re_o    (mem_re),
    .mem_we_o    (mem_we),
    .mem_rdata_i (mem_rdata),
    .halt_o      (halt)
  );

  // bench memory, one-cycle read latency
  logic [15:0] mem [256];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model: expected bus activity per cycle
  typedef struct {
    bit re; bit we; bit hl;
    logic [15:0] addr; logic [15:0] wd;
    string req;
  } ent_t;
  ent_t q[$];
  logic [15:0] ref_mem [256];
  logic [15:0] rf_m [16];

  task automatic push(input bit re, input bit we, input bit hl,
                      input logic [15:0] a, input logic [15:0] wd, input string req);
    ent_t e;
    e.re = re; e.we = we; e.hl = hl; e.addr = a; e.wd = wd; e.req = req;
    q.push_back(e);
  endtask

  task automatic put(input int a, input logic [15:0] w);
    mem[a] = w;
    ref_mem[a] = w;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin mem[i] = '0; ref_mem[i] = '0; end
  endtask

  task automatic build();
    logic [15:0] pc, ir;
    int rn, rm, steps;
    bit done;
    pc = '0; done = 0; steps = 0; q.delete();
    for (int i = 0; i < 16; i++) rf_m[i] = '0;
    while (!done && steps < 400) begin
      steps++;
      push(1, 0, 0, pc, '0, "R2");
      ir = ref_mem[pc[7:0]];
      pc = pc + 16'd1;
      push(0, 0, 0, '0, '0, "R2");
      rn = int'(ir[11:8]); rm = int'(ir[7:4]);
      case (ir[15:12])
        4'h0: begin
          push(1, 0, 0, {8'h00, ir[7:0]}, '0, "R3");
          push(0, 0, 0, '0, '0, "R3");
          rf_m[rn] = ref_mem[ir[7:0]];
        end
        4'h1: begin
          push(0, 1, 0, {8'h00, ir[7:0]}, rf_m[rn], "R4");
          ref_mem[ir[7:0]] = rf_m[rn];
        end
        4'h2: begin
          push(0, 1, 0, rf_m[rn], rf_m[rm], "R5");
          ref_mem[rf_m[rn][7:0]] = rf_m[rm];
        end
        4'h3: begin push(0, 0, 0, '0, '0, "R6"); rf_m[rn] = {8'h00, ir[7:0]}; end
        4'h4: begin push(0, 0, 0, '0, '0, "R7"); rf_m[rn] = rf_m[rn] + rf_m[rm]; end
        4'h5: begin push(0, 0, 0, '0, '0, "R8"); rf_m[rn] = rf_m[rn] - rf_m[rm]; end
        4'h6: begin
          push(0, 0, 0, '0, '0, "R9");
          if (rf_m[rn] == '0) pc = {8'h00, ir[7:0]};
        end
        default: begin
          for (int k = 0; k < 8; k++) push(0, 0, 1, '0, '0, "R10");
          done = 1;
        end
      endcase
    end
  endtask

  task automatic run_prog();
    ent_t e;
    rst_ni = 1'b0;
    build();
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk(mem_re == 1'b1 && mem_addr == 16'h0000, "R1", "reset read addr", {15'd0, mem_re, mem_addr}, 32'h0001_0000);
    chk(mem_we == 1'b0 && halt == 1'b0, "R1", "reset we/halt", {mem_we, halt}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    while (q.size() > 0) begin
      e = q.pop_front();
      chk(halt == e.hl, e.req, "halt", halt, e.hl);
      chk(mem_re == e.re && mem_we == e.we, (e.we || mem_we) ? "R11" : e.req, "re/we",
          {mem_re, mem_we}, {e.re, e.we});
      if (e.re || e.we) chk(mem_addr == e.addr, e.req, "addr", mem_addr, e.addr);
      if (e.we)         chk(mem_wdata == e.wd, e.req, "wdata", mem_wdata, e.wd);
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    // program A: immediates, arithmetic, loads and stores
    clear_mem();
    put(8'h00, 16'h3105); // LI r1,05
    put(8'h01, 16'h32FF); // LI r2,FF
    put(8'h02, 16'h4120); // ADD r1,r2
    put(8'h03, 16'h1180); // ST [80],r1
    put(8'h04, 16'h5320); // SUB r3,r2
    put(8'h05, 16'h1381); // ST [81],r3
    put(8'h06, 16'h0490); // LD r4,[90]
    put(8'h07, 16'h3582); // LI r5,82
    put(8'h08, 16'h2540); // STI [r5],r4
    put(8'h09, 16'h4640); // ADD r6,r4
    put(8'h0A, 16'h4660); // ADD r6,r6
    put(8'h0B, 16'h1683); // ST [83],r6
    put(8'h0C, 16'h1285); // ST [85],r2
    put(8'h0D, 16'hF000); // unknown opcode
    put(8'h90, 16'hBEEF);
    run_prog();
    chk(mem[8'h80] == 16'h0104, "R7", "sum stored",  mem[8'h80], 16'h0104);
    chk(mem[8'h81] == 16'hFF01, "R8", "diff wraps",  mem[8'h81], 16'hFF01);
    chk(mem[8'h82] == 16'hBEEF, "R5", "indirect",    mem[8'h82], 16'hBEEF);
    chk(mem[8'h83] == 16'h7DDE, "R7", "sum wraps",   mem[8'h83], 16'h7DDE);
    chk(mem[8'h85] == 16'h00FF, "R6", "zero ext",    mem[8'h85], 16'h00FF);
    chk(mem[8'h90] == 16'hBEEF, "R4", "source kept", mem[8'h90], 16'hBEEF);

    // program B: countdown loop with taken and untaken jumps
    clear_mem();
    put(8'h00, 16'h3000); // LI r0,0
    put(8'h01, 16'h3105); // LI r1,5
    put(8'h02, 16'h3201); // LI r2,1
    put(8'h03, 16'h3300); // LI r3,0
    put(8'h04, 16'h6108); // JZ r1,08
    put(8'h05, 16'h4010); // ADD r0,r1
    put(8'h06, 16'h5120); // SUB r1,r2
    put(8'h07, 16'h6304); // JZ r3,04
    put(8'h08, 16'h1084); // ST [84],r0
    put(8'h09, 16'h7000); // lowest unknown opcode
    run_prog();
    chk(mem[8'h84] == 16'h000F, "R9", "loop sum", mem[8'h84], 16'h000F);
    repeat (5) @(negedge clk);
    #1;
    chk(halt == 1'b1 && !mem_re && !mem_we, "R10", "still halted", {mem_re, mem_we, halt}, 3'b001);
    rst_ni = 1'b0;
    #1;
    chk(halt == 1'b0, "R10", "halt cleared by reset", halt, 1'b0);
    chk(mem_addr == 16'h0000 && mem_re, "R1", "pc cleared", mem_addr, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule